// File: doc/BRIEF.md
# Thermal Throttle Control Registers

This block is the small register unit that protects a memory controller against overheating. It holds two registers on a simple write/read bus. The first is an 8-bit control register. It has a halt-on-catastrophic enable and a self-locking freeze bit. The second is a 16-bit interrupt status register. It records rising and falling crossings of the hot trip point as separate flags, and software clears each flag by writing 1 to it.

Two sensor-side inputs drive the state. The catastrophic trip input is a level. The hot-trip crossing arrives as one-cycle pulses, with one input for each direction. When the enable is set, a catastrophic trip latches a clock-halt request, and only the platform reset releases it. The interrupt request is high while any status flag is set.

The bus writes on a single-cycle strobe. Reads are combinational from the address.

Top module: `thr_regs`

## Requirements
- R1: After platform reset (active-low `rst_n`), the control register reads 00h, the status register reads 0000h, and `clk_halt` and `irq` are low.
- R2: The control register sits at address 0. Its bits 7:4 and 2:1 always read 0, whatever value was written to them.
- R3: While the register is unlocked, bit 3 (halt enable) holds the last value written to it. That value can be read back on the cycle after the write.
- R4: Bit 0 of the control register is the lock. While it reads 1, writes to the control register change no bit, and that includes the lock itself.
- R5: Writing 0 to the lock never clears it. Only `rst_n` returns it to 0.
- R6: With the halt enable at 0, a high `cat_trip` leaves `clk_halt` low.
- R7: With the halt enable at 1, a high `cat_trip` raises `clk_halt` on the next cycle. It then stays high, even if the sensor drops or the enable is cleared, until `rst_n` is asserted.
- R8: The status register sits at address 2. Bit 0 is the rising-crossing flag and bit 1 is the falling-crossing flag. Each flag is set the cycle after a pulse on `hot_rise` or `hot_fall` respectively. Bits 15:2 read 0.
- R9: A status write with data bit 0 or bit 1 at 1 clears that flag. A data bit of 0 leaves its flag as it was.
- R10: A crossing pulse in the same cycle as a clearing write to its own flag leaves that flag set.
- R11: Each flag is set and cleared independently of the other. A falling crossing after the rising flag was cleared still sets bit 1. `irq` equals the OR of the two flags.
- R12: A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address (read and write) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cat_trip | input | 1 | Catastrophic sensor tripped (level) |
| hot_rise | input | 1 | Pulse: temperature rose past the hot trip point |
| hot_fall | input | 1 | Pulse: temperature fell past the hot trip point |
| clk_halt | output | 1 | Latched request to stop all clocks |
| irq | output | 1 | Interrupt request, OR of the status flags |

## Verification
The hardest case to reach is a crossing pulse that arrives in exactly the cycle of a clearing write, with either flag already set beforehand. The bench reaches it by first building each of the four initial flag states through pulses. It then applies one cycle that combines every clear mask with every pair of pulses, and compares the result against the set-or-keep formula. For the lock, the bench sweeps every write value both before and after locking, and it uses resets inside the run to show that only reset releases the lock and the halt.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int CTRL_W   = 8;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int HOC_BIT  = 3;
    localparam int LOCK_BIT = 0;
    localparam int RISE_BIT = 0;
    localparam int FALL_BIT = 1;

    typedef struct packed {
        logic hoc;
        logic lock;
        logic halt;
    } ctrl_st_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } stat_st_t;
endpackage

// File: rtl/thr_ctrl_reg.sv
module thr_ctrl_reg
    import thr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              cat_trip,
    output logic [CTRL_W-1:0] rd,
    output logic              halt
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && !st_q.lock) begin
            st_d.hoc  = wdata[HOC_BIT];
            st_d.lock = wdata[LOCK_BIT];
        end
        if (st_q.hoc && cat_trip)
            st_d.halt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd           = '0;
        rd[HOC_BIT]  = st_q.hoc;
        rd[LOCK_BIT] = st_q.lock;
    end

    assign halt = st_q.halt;

    a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && wr) |=> (st_q.lock && $stable(st_q.hoc)));
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);
    a_r6_no_halt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.hoc && !st_q.halt) |=> !halt);
    a_r7_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hoc && cat_trip) |=> halt);
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
endmodule

// File: rtl/thr_stat_reg.sv
module thr_stat_reg
    import thr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        clr,
    input  logic              ev_rise,
    input  logic              ev_fall,
    output logic [DATA_W-1:0] rd,
    output logic              irq
);
    stat_st_t st_d, st_q;
    logic     clr_rise, clr_fall;

    assign clr_rise = wr && clr[RISE_BIT];
    assign clr_fall = wr && clr[FALL_BIT];

    always_comb begin
        st_d = st_q;
        if (clr_rise) st_d.rise = 1'b0;
        if (clr_fall) st_d.fall = 1'b0;
        if (ev_rise)  st_d.rise = 1'b1;
        if (ev_fall)  st_d.fall = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd           = '0;
        rd[RISE_BIT] = st_q.rise;
        rd[FALL_BIT] = st_q.fall;
    end

    assign irq = st_q.rise | st_q.fall;

    a_r10_rise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rise |=> st_q.rise);
    a_r10_fall_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fall |=> st_q.fall);
    a_r9_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !ev_rise) |=> !st_q.rise);
    a_r9_fall_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fall && !clr_fall) |=> st_q.fall);
    a_r11_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rise || ev_fall) |=> irq);
endmodule

// File: rtl/thr_regs.sv
module thr_regs
    import thr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'd2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cat_trip,
    input  logic              hot_rise,
    input  logic              hot_fall,
    output logic              clk_halt,
    output logic              irq
);
    logic              wr_ctrl, wr_stat;
    logic [CTRL_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] stat_rd;
    logic              unused_hi;

    assign wr_ctrl   = bus_wr && (bus_addr == CTRL_ADDR);
    assign wr_stat   = bus_wr && (bus_addr == STAT_ADDR);
    assign unused_hi = ^bus_wdata[DATA_W-1:CTRL_W];

    thr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ctrl),
        .wdata    (bus_wdata[CTRL_W-1:0]),
        .cat_trip (cat_trip),
        .rd       (ctrl_rd),
        .halt     (clk_halt)
    );

    thr_stat_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_stat),
        .clr     (bus_wdata[1:0]),
        .ev_rise (hot_rise),
        .ev_fall (hot_fall),
        .rd      (stat_rd),
        .irq     (irq)
    );

    always_comb begin
        if (bus_addr == CTRL_ADDR)      bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_rd};
        else if (bus_addr == STAT_ADDR) bus_rdata = stat_rd;
        else                            bus_rdata = '0;
    end

    a_r11_irq_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_ADDR) |-> (irq == (bus_rdata != 16'h0)));
endmodule

// File: tb/sim_thr_regs.sv
module sim_thr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        cat_trip = 1'b0, hot_rise = 1'b0, hot_fall = 1'b0;
    logic        clk_halt, irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    thr_regs u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cat_trip = 1'b0; hot_rise = 1'b0; hot_fall = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic r, input logic f);
        @(negedge clk);
        hot_rise = r; hot_fall = f;
        @(negedge clk);
        hot_rise = 1'b0; hot_fall = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        do_reset();
        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(4'd2, v); chk("R1 stat", v, 16'h0000);
        chk("R1 halt", {15'd0, clk_halt}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2/R3 sweep every unlocked value (bit 0 clear)
        for (int i = 0; i < 256; i += 2) begin
            wr(4'd0, 16'(i) | 16'hFF00);
            rd(4'd0, v); chk("R2 R3 ctrl sweep", v, 16'(i) & 16'h0008);
        end
        // R12 unmapped addresses
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 2) begin
                rd(4'(a), v); chk("R12 unmapped", v, 16'h0000);
            end
        end

        // R6 trip with enable clear
        wr(4'd0, 16'h0000);
        @(negedge clk); cat_trip = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 no halt", {15'd0, clk_halt}, 16'd0);
        cat_trip = 1'b0;

        // R4/R5 lock with enable set, then sweep all writes
        wr(4'd0, 16'h0009);
        rd(4'd0, v); chk("R4 locked value", v, 16'h0009);
        for (int i = 0; i < 256; i++) begin
            wr(4'd0, 16'(i));
            rd(4'd0, v); chk("R4 R5 locked sweep", v, 16'h0009);
        end

        // R7 halt latch
        @(negedge clk); cat_trip = 1'b1;
        @(negedge clk);
        chk("R7 halt set", {15'd0, clk_halt}, 16'd1);
        cat_trip = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 halt held", {15'd0, clk_halt}, 16'd1);
        do_reset();
        rd(4'd0, v); chk("R5 reset unlocks", v, 16'h0000);
        chk("R7 reset releases", {15'd0, clk_halt}, 16'd0);

        // R7 halt survives enable clear while unlocked
        wr(4'd0, 16'h0008);
        @(negedge clk); cat_trip = 1'b1;
        @(negedge clk); cat_trip = 1'b0;
        wr(4'd0, 16'h0000);
        rd(4'd0, v); chk("R3 enable cleared", v, 16'h0000);
        chk("R7 halt after enable clear", {15'd0, clk_halt}, 16'd1);
        do_reset();

        // R8-R11 status sweep: initial flags x clear mask x events
        for (int init = 0; init < 4; init++) begin
            for (int m = 0; m < 4; m++) begin
                for (int e = 0; e < 4; e++) begin
                    logic [1:0] exp;
                    wr(4'd2, 16'h0003);
                    rd(4'd2, v); chk("R9 cleared", v, 16'h0000);
                    if (init != 0) pulse(init[0], init[1]);
                    rd(4'd2, v); chk("R8 flags set", v, 16'(init));
                    chk("R11 irq", {15'd0, irq}, {15'd0, init != 0});
                    @(negedge clk);
                    bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 16'hFFFC | 16'(m);
                    hot_rise = e[0]; hot_fall = e[1];
                    @(negedge clk);
                    bus_wr = 1'b0; hot_rise = 1'b0; hot_fall = 1'b0;
                    exp = 2'(e) | (2'(init) & ~2'(m));
                    #1 v = bus_rdata;
                    chk("R9 R10 R11 clear vs event", v, {14'd0, exp});
                    chk("R11 irq or", {15'd0, irq}, {15'd0, exp != 0});
                end
            end
        end

        // R11 fall after rise cleared
        wr(4'd2, 16'h0003);
        pulse(1'b1, 1'b0);
        wr(4'd2, 16'h0001);
        pulse(1'b0, 1'b1);
        rd(4'd2, v); chk("R11 fall after rise clear", v, 16'h0002);
        chk("R11 irq on fall", {15'd0, irq}, 16'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule